// File: doc/BRIEF.md
# DRAM Bank Row Timing Checker

This block watches a stream of row-level commands sent to a small multi-bank DRAM and judges each one against the row timing rules. It tracks whether each bank holds an open row. It keeps two saturating cycle counters per bank: one counting cycles since the last accepted activate, and one counting cycles since the bank was last closed. From this state it decides whether each command is legal. Every command gets a registered verdict with a reason code. A command that is rejected changes no bank state.

The rules it enforces are these:
- A bank must stay open for a minimum number of cycles before it may be closed.
- A closed bank needs a recovery time before it may be reopened.
- Refresh is allowed only while every bank is closed.
- Close-all is treated as a single event for all banks: it is accepted in full or rejected in full.

A bank that stays open past the maximum row-open time raises a sticky overrun flag. That flag is cleared only by reset.

The command input is a plain valid-qualified port. The checker samples one command on every clock where `cmd_valid` is high and never applies back-pressure, so it has no ready signal. All timing values are parameters counted in clock cycles.

Top module: `dram_row_checker`

## Requirements

Intervals below are counted in clock edges between the sampling edges of two commands. Command codes on `cmd_code` are: 0 no-op, 1 activate, 2 precharge one bank, 3 precharge all banks, 4 refresh, 5 to 7 undefined. Reason codes on `resp_cause` are: 0 legal, 1 activate to an open bank, 2 activate during recovery, 3 precharge too early, 4 refresh with a bank open, 5 undefined code.

- R1: After reset, all banks are closed, no overrun flag is set, and `resp_valid` is low. An activate to any bank is legal on the first command after reset.
- R2: Each cycle with `cmd_valid` high produces `resp_valid` high on the following cycle, carrying `resp_illegal` (which equals the reason code being non-zero) and `resp_cause`. A cycle without a command produces `resp_valid` low. A valid no-op is legal and changes nothing.
- R3: An activate to a closed bank whose recovery has elapsed opens that bank. An activate to an open bank is illegal with reason 1 and leaves the bank state unchanged.
- R4: An activate to a bank closed fewer than TRP cycles earlier is illegal with reason 2 and leaves the bank closed. At exactly TRP cycles it is legal.
- R5: A precharge to an open bank opened fewer than TRAS_MIN cycles earlier is illegal with reason 3, and the bank stays open. At TRAS_MIN cycles or more it is legal and closes the bank. A precharge to a closed bank is legal and has no effect.
- R6: A precharge-all is illegal with reason 3 and changes nothing if any open bank has been open for fewer than TRAS_MIN cycles. Otherwise it is legal and closes every open bank.
- R7: A refresh is illegal with reason 4 while any bank is open, and legal otherwise. In both cases it leaves all bank state unchanged.
- R8: A bank still open TRAS_MAX+1 cycles after its activate sets its overrun flag from that edge onward, even if a precharge closes the bank on that same edge. A precharge at exactly TRAS_MAX cycles leaves the flag clear. The flag stays set until reset.
- R9: Two accepted activates to the same bank are always at least TRAS_MIN+TRP cycles apart.
- R10: An undefined code (5 to 7) is illegal with reason 5 and leaves all bank state unchanged.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command code |
| cmd_bank | input | BANK_W | Target bank for activate and single-bank precharge |
| resp_valid | output | 1 | Verdict for the command sampled on the previous edge |
| resp_illegal | output | 1 | The command broke a rule |
| resp_cause | output | 3 | Reason code |
| bank_open | output | 2**BANK_W | One bit per bank, set while that bank holds an open row |
| bank_overrun | output | 2**BANK_W | Sticky per-bank flag for exceeding the maximum open time |

## Verification

Two functions can act on the same clock edge. One is the overrun detector, which sets a bank's flag once the bank has been open TRAS_MAX+1 cycles. The other is a precharge that closes that same bank on that exact edge. The bench provokes this with a directed sequence: an activate, then TRAS_MAX idle cycles, then a precharge. It expects the precharge to be reported legal, the bank to read closed, and the overrun flag to read set afterwards. A second directed run closes a bank one cycle earlier and expects the flag to stay clear. Randomized traffic then revisits the same boundary many times against a bench model of the rules.

// File: rtl/drtc_pkg.sv
`timescale 1ns/1ps
package drtc_pkg;

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_ACT  = 3'd1;
  localparam logic [2:0] OP_PRE  = 3'd2;
  localparam logic [2:0] OP_PREA = 3'd3;
  localparam logic [2:0] OP_REF  = 3'd4;

  typedef enum logic [2:0] {
    CZ_NONE      = 3'd0,
    CZ_ACT_OPEN  = 3'd1,
    CZ_ACT_RECOV = 3'd2,
    CZ_PRE_EARLY = 3'd3,
    CZ_REF_OPEN  = 3'd4,
    CZ_BAD_CODE  = 3'd5
  } cause_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/drtc_bank.sv
`timescale 1ns/1ps
module drtc_bank #(
  parameter int TRAS_MIN = 6,
  parameter int TRAS_MAX = 24,
  parameter int TRP      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic pre_go,
  output logic is_open,
  output logic tras_met,
  output logic trp_met,
  output logic overrun
);
  localparam int TRC       = TRAS_MIN + TRP;
  localparam int CNT_MAX_I = drtc_pkg::max3(TRAS_MAX + 1, TRC, TRP);
  localparam int CNT_W     = $clog2(CNT_MAX_I + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_OPEN = CNT_W'(TRAS_MIN);
  localparam logic [CNT_W-1:0] MAX_OPEN = CNT_W'(TRAS_MAX);
  localparam logic [CNT_W-1:0] RECOV    = CNT_W'(TRP);
  localparam logic [CNT_W-1:0] CYCLE    = CNT_W'(TRC);

  logic             open_q;
  logic             ovr_q;
  logic [CNT_W-1:0] act_age_q;
  logic [CNT_W-1:0] pre_age_q;
  logic             closing;

  assign closing = pre_go && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      ovr_q     <= 1'b0;
      act_age_q <= CNT_MAX;
      pre_age_q <= CNT_MAX;
    end else begin
      if (open_q && (act_age_q > MAX_OPEN)) ovr_q <= 1'b1;
      if (act_go) begin
        act_age_q <= ONE;
      end else if (act_age_q != CNT_MAX) begin
        act_age_q <= act_age_q + ONE;
      end
      if (closing) begin
        pre_age_q <= ONE;
      end else if (pre_age_q != CNT_MAX) begin
        pre_age_q <= pre_age_q + ONE;
      end
      if (act_go)       open_q <= 1'b1;
      else if (closing) open_q <= 1'b0;
    end
  end

  assign is_open  = open_q;
  assign tras_met = act_age_q >= MIN_OPEN;
  assign trp_met  = pre_age_q >= RECOV;
  assign overrun  = ovr_q;

  // R3: the judge only opens a bank that is closed
  p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> !open_q);
  // R4: the judge only opens a bank whose recovery has elapsed
  p_act_recov_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (pre_age_q >= RECOV));
  // R5: an open bank is only closed after its minimum open time
  p_pre_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    closing |-> (act_age_q >= MIN_OPEN));
  // R9: same-bank activates are a full row cycle apart
  p_act_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (act_age_q >= CYCLE));
  // R8: the overrun flag never clears outside reset
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

endmodule

// File: rtl/drtc_judge.sv
`timescale 1ns/1ps
module drtc_judge #(
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [NB-1:0]     is_open,
  input  logic [NB-1:0]     tras_met,
  input  logic [NB-1:0]     trp_met,
  output logic [NB-1:0]     act_go,
  output logic [NB-1:0]     pre_go,
  output logic              illegal,
  output drtc_pkg::cause_e  cause
);
  import drtc_pkg::*;

  logic any_open;
  logic any_early;

  assign any_open  = |is_open;
  assign any_early = |(is_open & ~tras_met);

  always_comb begin
    act_go = '0;
    pre_go = '0;
    cause  = CZ_NONE;
    if (cmd_valid) begin
      case (cmd_code)
        OP_NOP: cause = CZ_NONE;
        OP_ACT: begin
          if (is_open[cmd_bank])      cause = CZ_ACT_OPEN;
          else if (!trp_met[cmd_bank]) cause = CZ_ACT_RECOV;
          else                         act_go[cmd_bank] = 1'b1;
        end
        OP_PRE: begin
          if (is_open[cmd_bank] && !tras_met[cmd_bank]) cause = CZ_PRE_EARLY;
          else pre_go[cmd_bank] = is_open[cmd_bank];
        end
        OP_PREA: begin
          if (any_early) cause = CZ_PRE_EARLY;
          else           pre_go = is_open;
        end
        OP_REF: begin
          if (any_open) cause = CZ_REF_OPEN;
        end
        default: cause = CZ_BAD_CODE;
      endcase
    end
  end

  assign illegal = (cause != CZ_NONE);

endmodule

// File: rtl/drtc_resp.sv
`timescale 1ns/1ps
module drtc_resp (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_illegal,
  input  drtc_pkg::cause_e in_cause,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [2:0]       out_cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_cause   <= 3'd0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && in_illegal;
      out_cause   <= in_valid ? in_cause : 3'd0;
    end
  end
endmodule

// File: rtl/dram_row_checker.sv
`timescale 1ns/1ps
module dram_row_checker #(
  parameter int BANK_W   = 2,
  parameter int TRAS_MIN = 6,
  parameter int TRAS_MAX = 24,
  parameter int TRP      = 4,
  localparam int NB      = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              resp_valid,
  output logic              resp_illegal,
  output logic [2:0]        resp_cause,
  output logic [NB-1:0]     bank_open,
  output logic [NB-1:0]     bank_overrun
);
  import drtc_pkg::*;

  logic [NB-1:0] is_open;
  logic [NB-1:0] tras_met;
  logic [NB-1:0] trp_met;
  logic [NB-1:0] act_go;
  logic [NB-1:0] pre_go;
  logic          illegal_c;
  cause_e        cause_c;

  drtc_judge #(.BANK_W(BANK_W)) judge_i (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .is_open   (is_open),
    .tras_met  (tras_met),
    .trp_met   (trp_met),
    .act_go    (act_go),
    .pre_go    (pre_go),
    .illegal   (illegal_c),
    .cause     (cause_c)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    drtc_bank #(.TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX), .TRP(TRP)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_go   (act_go[b]),
      .pre_go   (pre_go[b]),
      .is_open  (is_open[b]),
      .tras_met (tras_met[b]),
      .trp_met  (trp_met[b]),
      .overrun  (bank_overrun[b])
    );
  end

  drtc_resp resp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (cmd_valid),
    .in_illegal  (illegal_c),
    .in_cause    (cause_c),
    .out_valid   (resp_valid),
    .out_illegal (resp_illegal),
    .out_cause   (resp_cause)
  );

  assign bank_open = is_open;

  // R2: one verdict per command, one cycle later
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(cmd_valid));
  // R2: at most one bank opened per cycle
  p_single_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_go));
  // R3: a rejected command leaves bank state alone
  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && illegal_c) |=> $stable(bank_open));
  // R7: refresh never changes bank state
  p_ref_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_REF) |=> $stable(bank_open));
  // R10: undefined codes are always rejected
  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code > OP_REF) |=> (resp_illegal && resp_cause == 3'd5));

endmodule

// File: tb/dram_row_checker_tb_top.sv
`timescale 1ns/1ps
module dram_row_checker_tb_top;
  localparam int BW = 2, NB = 4, TMIN = 6, TMAX = 24, TP = 4, SAT = 1000;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_PREA = 3'd3, C_REF = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic resp_valid, resp_illegal;
  logic [2:0] resp_cause;
  logic [NB-1:0] bank_open, bank_overrun;

  always #2.5 clk = ~clk;

  dram_row_checker #(.BANK_W(BW), .TRAS_MIN(TMIN), .TRAS_MAX(TMAX), .TRP(TP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .resp_valid(resp_valid), .resp_illegal(resp_illegal),
    .resp_cause(resp_cause), .bank_open(bank_open), .bank_overrun(bank_overrun));

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  bit m_open[NB], m_ovr[NB];
  int m_aage[NB], m_page[NB], last_act[NB];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_cause(input logic [2:0] code, input int b);
    bit any_open = 0, any_early = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_open[i]) any_open = 1;
      if (m_open[i] && m_aage[i] < TMIN) any_early = 1;
    end
    case (code)
      C_NOP:  return 0;
      C_ACT:  return m_open[b] ? 1 : ((m_page[b] < TP) ? 2 : 0);
      C_PRE:  return (m_open[b] && m_aage[b] < TMIN) ? 3 : 0;
      C_PREA: return any_early ? 3 : 0;
      C_REF:  return any_open ? 4 : 0;
      default: return 5;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] code, input int c);
    case (code)
      C_NOP:  return "R2";
      C_ACT:  return (c == 2) ? "R4" : "R3";
      C_PRE:  return "R5";
      C_PREA: return "R6";
      C_REF:  return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic int vec_open();
    int v = 0;
    for (int i = 0; i < NB; i++) if (m_open[i]) v |= (1 << i);
    return v;
  endfunction

  function automatic int vec_ovr();
    int v = 0;
    for (int i = 0; i < NB; i++) if (m_ovr[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic model_update(input bit v, input logic [2:0] code, input int b, input int c);
    bit act[NB], cls[NB];
    for (int i = 0; i < NB; i++) begin
      act[i] = 0; cls[i] = 0;
      if (m_open[i] && m_aage[i] > TMAX) m_ovr[i] = 1;
    end
    if (v && c == 0) begin
      if (code == C_ACT) act[b] = 1;
      if (code == C_PRE && m_open[b]) cls[b] = 1;
      if (code == C_PREA) for (int i = 0; i < NB; i++) cls[i] = m_open[i];
    end
    for (int i = 0; i < NB; i++) begin
      m_aage[i] = act[i] ? 1 : ((m_aage[i] < SAT) ? m_aage[i] + 1 : SAT);
      m_page[i] = cls[i] ? 1 : ((m_page[i] < SAT) ? m_page[i] + 1 : SAT);
      if (act[i]) m_open[i] = 1;
      else if (cls[i]) m_open[i] = 0;
    end
  endtask

  task automatic step(input bit v, input logic [2:0] code, input int b);
    int c;
    string t;
    c = v ? model_cause(code, b) : 0;
    t = tag_of(code, c);
    cmd_valid = v; cmd_code = code; cmd_bank = BW'(b);
    @(posedge clk);
    model_update(v, code, b, c);
    cyc++;
    @(negedge clk);
    check(resp_valid === v, "R2", "resp_valid", int'(resp_valid), int'(v));
    if (v) begin
      check(resp_cause == 3'(c), t, "resp_cause", int'(resp_cause), c);
      check(resp_illegal == (c != 0), "R2", "resp_illegal", int'(resp_illegal), int'(c != 0));
      if (code == C_ACT && resp_illegal === 1'b0) begin
        check(cyc - last_act[b] >= TMIN + TP, "R9", "act spacing", cyc - last_act[b], TMIN + TP);
        last_act[b] = cyc;
      end
    end
    check(int'(bank_open) == vec_open(), v ? t : "R2", "bank_open", int'(bank_open), vec_open());
    check(int'(bank_overrun) == vec_ovr(), "R8", "bank_overrun", int'(bank_overrun), vec_ovr());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, C_NOP, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_ovr[i] = 0; m_aage[i] = SAT; m_page[i] = SAT; last_act[i] = -SAT;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(resp_valid === 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
    check(bank_open === '0, "R1", "bank_open after reset", int'(bank_open), 0);
    check(bank_overrun === '0, "R1", "overrun after reset", int'(bank_overrun), 0);
    // R1: activate legal right away
    step(1, C_ACT, 0);
    check(resp_cause == 3'd0, "R1", "first activate", int'(resp_cause), 0);
    step(1, C_ACT, 0);          // R3 open bank
    idle(TMIN - 3);
    step(1, C_PRE, 0);          // R5 at TMIN-1: early
    step(1, C_PRE, 0);          // R5 at TMIN: legal
    step(1, C_PRE, 0);          // R5 closed bank no-op
    idle(TP - 3);
    step(1, C_ACT, 0);          // R4 at TP-1
    step(1, C_ACT, 0);          // R4 at TP, R9 spacing
    step(1, C_ACT, 1);
    step(1, C_REF, 0);          // R7 with banks open
    step(1, C_PREA, 0);         // R6 early
    idle(TMIN);
    step(1, C_PREA, 0);         // R6 legal closes both
    check(bank_open == '0, "R6", "all closed", int'(bank_open), 0);
    step(1, C_REF, 0);          // R7 legal
    step(1, C_NOP, 0);          // R2 valid no-op
    // R8: close at exactly TMAX keeps flag clear
    step(1, C_ACT, 2);
    idle(TMAX - 1);
    step(1, C_PRE, 2);
    check(bank_overrun[2] == 1'b0, "R8", "no overrun at max", int'(bank_overrun[2]), 0);
    // R8: close at TMAX+1 sets flag on the same edge
    step(1, C_ACT, 3);
    idle(TMAX);
    step(1, C_PRE, 3);
    check(resp_illegal == 1'b0, "R8", "late close legal", int'(resp_illegal), 0);
    check(bank_open[3] == 1'b0, "R8", "late close closed", int'(bank_open[3]), 0);
    check(bank_overrun[3] == 1'b1, "R8", "overrun same edge", int'(bank_overrun[3]), 1);
    step(1, C_ACT, 1);
    for (int k = 5; k < 8; k++) step(1, 3'(k), 1);   // R10
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r, b;
      logic [2:0] code;
      r = int'($urandom % 100);
      b = int'($urandom % NB);
      if (r < 40)      code = C_ACT;
      else if (r < 75) code = C_PRE;
      else if (r < 84) code = C_PREA;
      else if (r < 92) code = C_REF;
      else if (r < 96) code = C_NOP;
      else             code = 3'(5 + ($urandom % 3));
      if (($urandom % 100) < 35) step(0, C_NOP, 0);
      else step(1, code, b);
    end
    finish_run();
  end
endmodule